// File: doc/BRIEF.md
# Supervisor Trap-Entry Guard

This block keeps a single hidden bit that records whether the hart is inside the critical opening part of a supervisor trap handler. It decides what happens when a trap enters supervisor mode and when a supervisor return executes. On a first-level entry it exchanges integer register x1 with a dedicated scratch CSR in hardware and sets the hidden bit. The handler therefore starts with a usable base pointer in x1 and needs no swap instruction. On a nested entry, taken while the bit is still set, no register is touched and only the PC is steered to a separate double-fault vector.

Software leaves the critical section with a dedicated clear strobe once it has saved whatever a nested trap would overwrite. A supervisor return is legal only inside the critical section and ends it. The bit is not part of any visible status register. It is forced clear whenever the hart runs user code. While the hart runs in hypervisor or machine mode it is frozen, so its value is the same on the return to supervisor mode.

The block drives the register-file write enable and data for x1, a write strobe for the scratch CSR, a next-PC select with its vector address, and an illegal-instruction flag. Privilege is encoded as 0 = user, 1 = supervisor, 2 = hypervisor, 3 = machine.

Top module: `trap_guard`

## Requirements
- R1: A trap with `trapReq`=1, `trapPriv`=1 and `curPriv` of 0 or 1 is a supervisor entry. With the hidden bit clear, in that same cycle `x1WrEn`=1, `x1WrData` equals the scratch CSR value, `scratchWrEn`=1, `pcSel`=1 (trap) and `pcTarget`=TRAP_VEC. On the next cycle the scratch CSR holds the `x1Rd` value of the entry cycle and the hidden bit is set.
- R2: A supervisor entry with the hidden bit set gives `pcSel`=2 (double fault) and `pcTarget`=DFAULT_VEC, with `x1WrEn`=0 and `scratchWrEn`=0. The scratch CSR and the bit are unchanged.
- R3: `sretValid` in supervisor mode with no trap and the bit clear gives `illegalInstr`=1 and `pcSel`=0 in that cycle. It changes neither the bit nor the scratch CSR.
- R4: `sretValid` in supervisor mode with no trap and the bit set gives `pcSel`=3 (return) and `illegalInstr`=0. The bit is clear from the next cycle.
- R5: A cycle with `curPriv`=0 and no supervisor entry leaves the bit clear on the next cycle.
- R6: While `curPriv` is 2 or 3, the bit keeps its value, and `sretValid`, `flagClr` and supervisor-targeted traps produce no output: `pcSel`=0, `illegalInstr`=0, no writes.
- R7: `flagClr` in supervisor mode clears the bit from the next cycle. A supervisor entry in the same cycle takes precedence and the bit ends up set.
- R8: When `trapReq` and `sretValid` are both 1, the return is dropped: no `illegalInstr`, `pcSel` is never 3, and the return does not clear the bit.
- R9: A trap whose `trapPriv` is 0, 2 or 3 produces no output from this block and leaves the scratch CSR unchanged.
- R10: `csrWrEn` loads `csrWrData` into the scratch CSR on the next cycle. The hardware swap of R1 takes precedence in the same cycle.
- R11: After reset the bit is clear, the scratch CSR reads SCRATCH_INIT, and the trap and double-fault vectors hold TRAP_VEC and DFAULT_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | A trap is being taken this cycle |
| trapPriv | input | 2 | Privilege level the trap targets |
| curPriv | input | 2 | Privilege level the hart currently runs at |
| sretValid | input | 1 | A supervisor return is decoded this cycle |
| flagClr | input | 1 | Software strobe that ends the critical section |
| csrWrEn | input | 1 | Software write of the scratch CSR |
| csrWrData | input | XLEN | Data for the scratch CSR write |
| x1Rd | input | XLEN | Current value of integer register x1 |
| x1WrEn | output | 1 | Write enable for x1 in the register file |
| x1WrData | output | XLEN | Value to write into x1 |
| scratchWrEn | output | 1 | Scratch CSR is loaded from x1 this cycle |
| scratchRdData | output | XLEN | Current scratch CSR contents |
| pcSel | output | 2 | Next-PC select: 0 none, 1 trap, 2 double fault, 3 return |
| pcTarget | output | XLEN | Vector address for trap and double fault, zero otherwise |
| illegalInstr | output | 1 | The decoded return is illegal |

## Verification
The bench drives every combination of trap request, trap target, current privilege, return decode and clear strobe. It does this once with the hidden bit clear and once with it set, and brings the bit to each state through the block's own entry and clear paths. Comparing the two bit states shows the swap apart from the double-fault redirect, and an illegal return apart from a legal one. The user, supervisor and hypervisor/machine settings of `curPriv` separate the forced clear from the frozen bit and from normal operation. The trap-with-return cases show the priority rule. The bit cannot be seen directly, so every later vector acts as a probe of the state the earlier ones left. A changing `x1Rd` pattern, together with interleaved scratch writes, makes each swap traceable to the cycle that caused it.

// File: rtl/trap_guard_pkg.sv
package trap_guard_pkg;

  localparam int PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_HYPER = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    PC_NONE   = 2'd0,
    PC_TRAP   = 2'd1,
    PC_DFAULT = 2'd2,
    PC_RETURN = 2'd3
  } pc_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    swapEn;    // exchange x1 and scratch
    logic    setFlag;   // enter critical section
    logic    clrFlag;   // leave critical section
    pc_sel_e pcSel;     // next-PC source
    logic    illegal;   // decoded return is illegal
  } guard_ctl_t;

endpackage

// File: rtl/trap_guard_ctrl.sv
module trap_guard_ctrl
  import trap_guard_pkg::*;
(
  input  logic              trapReq,
  input  logic [PRIV_W-1:0] trapPriv,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              sretValid,
  input  logic              flagClr,
  input  logic              flagQ,
  output guard_ctl_t        ctl
);

  logic lowPriv;    // hart in user or supervisor mode
  logic inSuper;
  logic inUser;
  logic superEntry;
  logic retAct;

  always_comb begin
    inUser     = (curPriv == PRIV_USER);
    inSuper    = (curPriv == PRIV_SUPER);
    lowPriv    = inUser || inSuper;
    superEntry = trapReq && (trapPriv == PRIV_SUPER) && lowPriv;
    // a trap of any kind pre-empts a return in the same cycle
    retAct     = sretValid && !trapReq && inSuper;
  end

  always_comb begin
    ctl = '{swapEn: 1'b0, setFlag: 1'b0, clrFlag: 1'b0,
            pcSel: PC_NONE, illegal: 1'b0};
    if (superEntry) begin
      ctl.setFlag = 1'b1;
      if (flagQ) begin
        ctl.pcSel = PC_DFAULT;
      end else begin
        ctl.swapEn = 1'b1;
        ctl.pcSel  = PC_TRAP;
      end
    end else if (inUser) begin
      ctl.clrFlag = 1'b1;
    end else if (inSuper) begin
      if (retAct) begin
        if (flagQ) begin
          ctl.pcSel   = PC_RETURN;
          ctl.clrFlag = 1'b1;
        end else begin
          ctl.illegal = 1'b1;
        end
      end else if (flagClr) begin
        ctl.clrFlag = 1'b1;
      end
    end
  end

endmodule

// File: rtl/trap_guard_dpath.sv
module trap_guard_dpath
  import trap_guard_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] TRAP_VEC     = '0,
  parameter logic [XLEN-1:0] DFAULT_VEC   = '0,
  parameter logic [XLEN-1:0] SCRATCH_INIT = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  guard_ctl_t      ctl,
  input  logic            csrWrEn,
  input  logic [XLEN-1:0] csrWrData,
  input  logic [XLEN-1:0] x1Rd,
  output logic            flagQ,
  output logic [XLEN-1:0] scratchQ,
  output logic [XLEN-1:0] x1WrData,
  output logic [XLEN-1:0] pcTarget
);

  logic [XLEN-1:0] trapVecQ;
  logic [XLEN-1:0] dfaultVecQ;

  // hidden critical-section bit; set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (ctl.setFlag) begin
      flagQ <= 1'b1;
    end else if (ctl.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  // scratch CSR: hardware swap wins over software write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchQ <= SCRATCH_INIT;
    end else if (ctl.swapEn) begin
      scratchQ <= x1Rd;
    end else if (csrWrEn) begin
      scratchQ <= csrWrData;
    end
  end

  // vector registers loaded at reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapVecQ   <= TRAP_VEC;
      dfaultVecQ <= DFAULT_VEC;
    end
  end

  assign x1WrData = scratchQ;

  always_comb begin
    unique case (ctl.pcSel)
      PC_TRAP:   pcTarget = trapVecQ;
      PC_DFAULT: pcTarget = dfaultVecQ;
      default:   pcTarget = '0;
    endcase
  end

endmodule

// File: rtl/trap_guard.sv
module trap_guard
  import trap_guard_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] TRAP_VEC     = 32'h0000_0100,
  parameter logic [XLEN-1:0] DFAULT_VEC   = 32'h0000_0200,
  parameter logic [XLEN-1:0] SCRATCH_INIT = 32'h0000_8000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [1:0]      trapPriv,
  input  logic [1:0]      curPriv,
  input  logic            sretValid,
  input  logic            flagClr,
  input  logic            csrWrEn,
  input  logic [XLEN-1:0] csrWrData,
  input  logic [XLEN-1:0] x1Rd,
  output logic            x1WrEn,
  output logic [XLEN-1:0] x1WrData,
  output logic            scratchWrEn,
  output logic [XLEN-1:0] scratchRdData,
  output logic [1:0]      pcSel,
  output logic [XLEN-1:0] pcTarget,
  output logic            illegalInstr
);

  guard_ctl_t      ctl;
  logic            flagQ;
  logic [XLEN-1:0] scratchQ;

  trap_guard_ctrl ctrl_i (
    .trapReq   (trapReq),
    .trapPriv  (trapPriv),
    .curPriv   (curPriv),
    .sretValid (sretValid),
    .flagClr   (flagClr),
    .flagQ     (flagQ),
    .ctl       (ctl)
  );

  trap_guard_dpath #(
    .XLEN         (XLEN),
    .TRAP_VEC     (TRAP_VEC),
    .DFAULT_VEC   (DFAULT_VEC),
    .SCRATCH_INIT (SCRATCH_INIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .csrWrEn   (csrWrEn),
    .csrWrData (csrWrData),
    .x1Rd      (x1Rd),
    .flagQ     (flagQ),
    .scratchQ  (scratchQ),
    .x1WrData  (x1WrData),
    .pcTarget  (pcTarget)
  );

  assign x1WrEn        = ctl.swapEn;
  assign scratchWrEn   = ctl.swapEn;
  assign scratchRdData = scratchQ;
  assign pcSel         = ctl.pcSel;
  assign illegalInstr  = ctl.illegal;

endmodule

// File: rtl/trap_guard_chk.sv
module trap_guard_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapReq,
  input logic [1:0]      trapPriv,
  input logic [1:0]      curPriv,
  input logic            sretValid,
  input logic            x1WrEn,
  input logic            scratchWrEn,
  input logic [XLEN-1:0] x1Rd,
  input logic [XLEN-1:0] scratchRdData,
  input logic [1:0]      pcSel,
  input logic            illegalInstr,
  input logic            flagQ
);

  logic superEntry;
  assign superEntry = trapReq && (trapPriv == 2'd1) && !curPriv[1];

  // R1
  first_entry_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    superEntry && !flagQ |=> flagQ && (scratchRdData == $past(x1Rd)));

  // R2
  nested_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    superEntry && flagQ |-> !x1WrEn && !scratchWrEn && (pcSel == 2'd2));

  // R3
  bad_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    sretValid && !trapReq && (curPriv == 2'd1) && !flagQ
      |-> illegalInstr ##1 !flagQ);

  // R5
  user_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curPriv == 2'd0) && !superEntry |=> !flagQ);

  // R6
  upper_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPriv[1] |=> (flagQ == $past(flagQ)));

  // R6
  upper_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPriv[1] |-> (pcSel == 2'd0) && !illegalInstr && !x1WrEn);

  // R8
  trap_beats_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && sretValid |-> !illegalInstr && (pcSel != 2'd3));

  // R1
  swap_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    x1WrEn == scratchWrEn);

endmodule

bind trap_guard trap_guard_chk #(.XLEN(XLEN)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .trapReq       (trapReq),
  .trapPriv      (trapPriv),
  .curPriv       (curPriv),
  .sretValid     (sretValid),
  .x1WrEn        (x1WrEn),
  .scratchWrEn   (scratchWrEn),
  .x1Rd          (x1Rd),
  .scratchRdData (scratchRdData),
  .pcSel         (pcSel),
  .illegalInstr  (illegalInstr),
  .flagQ         (flagQ)
);

// File: tb/trap_guard_tb_top.sv
module trap_guard_tb_top;

  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] TV = 32'h0000_0100;
  localparam logic [XLEN-1:0] DV = 32'h0000_0200;
  localparam logic [XLEN-1:0] SI = 32'h0000_8000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            trapReq = 1'b0;
  logic [1:0]      trapPriv = 2'd0;
  logic [1:0]      curPriv = 2'd1;
  logic            sretValid = 1'b0;
  logic            flagClr = 1'b0;
  logic            csrWrEn = 1'b0;
  logic [XLEN-1:0] csrWrData = '0;
  logic [XLEN-1:0] x1Rd = '0;
  logic            x1WrEn;
  logic [XLEN-1:0] x1WrData;
  logic            scratchWrEn;
  logic [XLEN-1:0] scratchRdData;
  logic [1:0]      pcSel;
  logic [XLEN-1:0] pcTarget;
  logic            illegalInstr;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // bench model state
  bit              mFlag = 1'b0;
  logic [XLEN-1:0] mScr = SI;
  int              seq = 0;

  always #2 clk = ~clk;   // 250 MHz

  trap_guard #(.XLEN(XLEN), .TRAP_VEC(TV), .DFAULT_VEC(DV),
               .SCRATCH_INIT(SI)) dut_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapPriv(trapPriv),
    .curPriv(curPriv), .sretValid(sretValid), .flagClr(flagClr),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .x1Rd(x1Rd),
    .x1WrEn(x1WrEn), .x1WrData(x1WrData), .scratchWrEn(scratchWrEn),
    .scratchRdData(scratchRdData), .pcSel(pcSel), .pcTarget(pcTarget),
    .illegalInstr(illegalInstr)
  );

  task automatic step(input bit t, input logic [1:0] tp, input logic [1:0] cp,
                      input bit sr, input bit clr, input bit cw);
    bit entry, retS;
    bit eWr, eIll;
    logic [1:0] eSel;
    logic [XLEN-1:0] eTgt, eData;
    string tag;
    @(negedge clk);
    seq++;
    trapReq = t; trapPriv = tp; curPriv = cp; sretValid = sr;
    flagClr = clr; csrWrEn = cw;
    csrWrData = 32'h5000_0000 + seq;
    x1Rd = 32'hA000_0000 + (seq * 7);
    #1;
    entry = t && (tp == 2'd1) && (cp <= 2'd1);
    retS  = sr && !t && (cp == 2'd1);
    eWr = 0; eIll = 0; eSel = 2'd0; eTgt = '0; eData = mScr;
    if (cp >= 2'd2)          tag = "R6";
    else if (entry && !mFlag) tag = "R1";
    else if (entry)          tag = "R2";
    else if (t && sr)        tag = "R8";
    else if (t)              tag = "R9";
    else if (retS)           tag = mFlag ? "R4" : "R3";
    else if (cp == 2'd0)     tag = "R5";
    else if (clr)            tag = "R7";
    else                     tag = "R10";
    if (entry && !mFlag) begin eWr = 1; eSel = 2'd1; eTgt = TV; end
    else if (entry)      begin eSel = 2'd2; eTgt = DV; end
    else if (retS) begin
      if (mFlag) eSel = 2'd3; else eIll = 1;
    end
    nVec++;
    if (x1WrEn !== eWr || scratchWrEn !== eWr || pcSel !== eSel ||
        pcTarget !== eTgt || illegalInstr !== eIll ||
        scratchRdData !== mScr || (eWr && x1WrData !== eData)) begin
      nBad++;
      $display("FAIL %s vec %0d: wr=%b/%b sel=%0d tgt=%h ill=%b scr=%h x1d=%h exp wr=%b sel=%0d tgt=%h ill=%b scr=%h x1d=%h",
               tag, seq, x1WrEn, scratchWrEn, pcSel, pcTarget, illegalInstr,
               scratchRdData, x1WrData, eWr, eSel, eTgt, eIll, mScr, eData);
    end
    // advance model after the edge
    if (entry && !mFlag) mScr = x1Rd;
    else if (cw)         mScr = csrWrData;
    if (entry)                       mFlag = 1;
    else if (cp == 2'd0)             mFlag = 0;
    else if (cp == 2'd1 && retS && mFlag) mFlag = 0;
    else if (cp == 2'd1 && !retS && clr)  mFlag = 0;
  endtask

  // bring hidden bit to a wanted state through the normal paths
  task automatic force_flag(input bit want);
    if (want && !mFlag) step(1, 2'd1, 2'd1, 0, 0, 0);   // R1 entry
    if (!want && mFlag) step(0, 2'd0, 2'd1, 0, 1, 0);   // R7 clear
  endtask

  initial begin : watchdog
    #400000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state, flag clear shown by an illegal return
    step(0, 2'd0, 2'd1, 1, 0, 0);           // R3 after R11 reset
    step(1, 2'd1, 2'd1, 0, 0, 0);           // R1 first entry, R11 trap vector
    step(1, 2'd1, 2'd1, 0, 0, 0);           // R2 nested, R11 dfault vector
    step(0, 2'd0, 2'd1, 1, 0, 0);           // R4 legal return
    step(0, 2'd0, 2'd1, 1, 0, 0);           // R3 now illegal
    // R7: clear racing an entry: entry wins
    step(1, 2'd1, 2'd1, 0, 1, 1);           // R7, R10 swap over write
    step(1, 2'd1, 2'd1, 0, 0, 0);           // R7 expects double fault
    // full sweep
    for (int fs = 0; fs < 2; fs++)
      for (int t = 0; t < 2; t++)
        for (int tp = 0; tp < 4; tp++)
          for (int cp = 0; cp < 4; cp++)
            for (int sr = 0; sr < 2; sr++)
              for (int clr = 0; clr < 2; clr++) begin
                force_flag(fs[0]);
                step(t[0], tp[1:0], cp[1:0], sr[0], clr[0], ((seq % 3) == 0));
                // probe the bit left behind (R5, R6, R7, R8 effects)
                step(0, 2'd0, 2'd1, 1, 0, 0);
              end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule